// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block is the receive side of a synchronous serial port operating as a clock slave. An external master drives the serial clock and data lines. The block passes both through a synchronizer into the system clock domain, detects the selected active edge of the serial clock and gathers one bit per active edge, least significant bit first. Words are 8 or 9 bits long. When the last bit of a word arrives, the word is copied into a buffered data register, a receive-complete flag is set and, if enabled, an interrupt request is raised.

Software uses a small register port to configure the receiver, read status and read data. The receiver runs only from the external clock and the system clock, so it keeps accepting words while the rest of the system sits in a sleep or idle state. In that state its completion interrupt serves as the wake-up event. A word that completes while the previous word is still unread causes an overrun. Overrun blocks all further loads until software clears the continuous-receive enable bit. Clearing that bit is the only way to clear the error.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, the control register (address 0), the status register (address 1), the data register (address 2) and `irq` all read zero.
- R2: Control register bits are: bit0 port enable, bit1 synchronous mode, bit2 master clock select, bit3 continuous-receive enable, bit4 single-receive request, bit5 9-bit words, bit6 falling-edge select, bit7 interrupt enable. Bits are shifted in only while bit0, bit1 and bit3 are 1 and bit2 is 0. Serial clock edges at any other time have no effect on data or status.
- R3: The single-receive request bit (control bit4) has no effect. With bit3 set, words are received whatever bit4 holds. With bit3 clear and bit4 set, nothing is received.
- R4: Bits are taken least significant first. A bit is sampled on the rising serial clock edge when control bit6 is 0 and on the falling edge when it is 1.
- R5: In 8-bit mode (control bit5 = 0), the 8th active edge of a word copies the word into the data register and sets status bit2 (receive complete). Status bit0 then reads 0.
- R6: In 9-bit mode (control bit5 = 1), a word takes 9 active edges. Its low 8 bits go to the data register and bit 8 goes to status bit0. Status bit0 keeps its value until the next accepted word.
- R7: `irq` is high exactly while status bit2 and control bit7 are both 1.
- R8: A read of address 2 with `regRdEn` high clears status bit2.
- R9: When a word completes while status bit2 is 1, status bit1 (overrun) is set and the new word is discarded. While bit1 is 1, no later word changes the data register or status bit0, even after the data has been read.
- R10: Clearing control bit3 clears status bit1 and aborts any partly received word, so the next word after re-enabling starts from bit 0.
- R11: Writes to addresses 1 to 3 have no effect, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial clock from the external master |
| serData | input | 1 | Serial data line |
| regAddr | input | 2 | Register address: 0 control, 1 status, 2 data |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdEn | input | 1 | Register read strobe (a data read clears receive complete) |
| regRdData | output | 8 | Register read data (combinational) |
| irq | output | 1 | Receive-complete interrupt request |

## Verification
Assertions check the following on every cycle: the bit counter stays inside the word length and returns to zero whenever the receiver is not in slave mode; overrun is cleared once continuous receive is dropped and rises only while a word is already pending; and the data register changes only on a load strobe. The bench scenarios cover the rest. These are the bit order and edge polarity of received words, the 8-bit and 9-bit formats, the single-receive bit having no effect, and the overrun sequence that discards words even after a read. They also cover recovery from a partial word and the interrupt gating. They use both directed cases and a seeded random stream of words.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int CTL_PORT_EN = 0;
  localparam int CTL_SYNC    = 1;
  localparam int CTL_MASTER  = 2;
  localparam int CTL_CONT    = 3;
  localparam int CTL_SINGLE  = 4;
  localparam int CTL_NINE    = 5;
  localparam int CTL_FALL    = 6;
  localparam int CTL_IRQ_EN  = 7;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_DATA   = 2'd2;

  typedef struct packed {
    logic shiftEn;
    logic loadData;
    logic keepNinth;
  } rxStrobe_t;
endpackage

// File: rtl/sync_rx_datapath.sv
module sync_rx_datapath
  import sync_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = DATA_W + 1,
  localparam int CNT_W      = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              edgeFall,
  input  rxStrobe_t         strobes,
  input  logic [CNT_W-1:0]  bitIdx,
  output logic              edgeSeen,
  output logic [DATA_W-1:0] rxData,
  output logic              ninthBit
);
  logic [SYNC_STAGES:0]   clkPipe;
  logic [SYNC_STAGES-1:0] dataPipe;
  logic [WORD_W-1:0]      shiftReg;
  logic [WORD_W-1:0]      nextWord;
  logic clkNow, clkPrev, sampleBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe  <= '0;
      dataPipe <= '0;
    end else begin
      clkPipe  <= {clkPipe[SYNC_STAGES-1:0], serClk};
      dataPipe <= {dataPipe[SYNC_STAGES-2:0], serData};
    end
  end

  assign clkNow    = clkPipe[SYNC_STAGES-1];
  assign clkPrev   = clkPipe[SYNC_STAGES];
  assign sampleBit = dataPipe[SYNC_STAGES-1];
  assign edgeSeen  = edgeFall ? (clkPrev & ~clkNow) : (clkNow & ~clkPrev);

  always_comb begin
    nextWord = shiftReg;
    nextWord[bitIdx] = sampleBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxData   <= '0;
      ninthBit <= 1'b0;
    end else begin
      if (strobes.shiftEn) shiftReg <= nextWord;
      if (strobes.loadData) begin
        rxData   <= nextWord[DATA_W-1:0];
        ninthBit <= strobes.keepNinth ? nextWord[DATA_W] : 1'b0;
      end
    end
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadData |=> $stable(rxData)); // R9
  AST_LOAD_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadData |-> edgeSeen); // R4
endmodule

// File: rtl/sync_rx_ctrl.sv
module sync_rx_ctrl
  import sync_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  localparam int WORD_W = DATA_W + 1,
  localparam int CNT_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  input  logic             regRdEn,
  input  logic             edgeSeen,
  output rxStrobe_t        strobes,
  output logic [CNT_W-1:0] bitIdx,
  output logic [7:0]       ctrlReg,
  output logic             rxDone,
  output logic             overrun,
  output logic             irq
);
  logic slaveActive, lastBit, wordDone, dataRead;
  logic [CNT_W-1:0] wordLast;

  assign slaveActive = ctrlReg[CTL_PORT_EN] & ctrlReg[CTL_SYNC] &
                       ~ctrlReg[CTL_MASTER] & ctrlReg[CTL_CONT];
  assign wordLast = ctrlReg[CTL_NINE] ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
  assign lastBit  = (bitIdx == wordLast);
  assign wordDone = strobes.shiftEn & lastBit;
  assign dataRead = regRdEn & (regAddr == ADDR_DATA);

  always_comb begin
    strobes.shiftEn   = slaveActive & edgeSeen;
    strobes.loadData  = wordDone & ~overrun & ~rxDone;
    strobes.keepNinth = ctrlReg[CTL_NINE];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      bitIdx  <= '0;
      rxDone  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (regWrEn && regAddr == ADDR_CTRL) ctrlReg <= regWrData;

      if (!slaveActive)           bitIdx <= '0;
      else if (strobes.shiftEn)   bitIdx <= lastBit ? '0 : bitIdx + 1'b1;

      if (!ctrlReg[CTL_CONT])                 overrun <= 1'b0;
      else if (wordDone && rxDone && !overrun) overrun <= 1'b1;

      if (strobes.loadData) rxDone <= 1'b1;
      else if (dataRead)    rxDone <= 1'b0;
    end
  end

  assign irq = rxDone & ctrlReg[CTL_IRQ_EN];

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= CNT_W'(DATA_W)); // R6
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    !slaveActive |=> bitIdx == '0); // R2
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[CTL_CONT] |=> !overrun); // R10
  AST_OVR_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxDone)); // R9
  AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadData |=> rxDone); // R5
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sync_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serData,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       regRdEn,
  output logic [7:0] regRdData,
  output logic       irq
);
  rxStrobe_t         strobes;
  logic [CNT_W-1:0]  bitIdx;
  logic [7:0]        ctrlReg;
  logic              rxDone, overrun, edgeSeen, ninthBit;
  logic [DATA_W-1:0] rxData;

  sync_rx_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .edgeSeen(edgeSeen),
    .strobes(strobes), .bitIdx(bitIdx), .ctrlReg(ctrlReg),
    .rxDone(rxDone), .overrun(overrun), .irq(irq)
  );

  sync_rx_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .edgeFall(ctrlReg[CTL_FALL]), .strobes(strobes), .bitIdx(bitIdx),
    .edgeSeen(edgeSeen), .rxData(rxData), .ninthBit(ninthBit)
  );

  always_comb begin
    case (regAddr)
      ADDR_CTRL:   regRdData = ctrlReg;
      ADDR_STATUS: regRdData = {5'b0, rxDone, overrun, ninthBit};
      ADDR_DATA:   regRdData = 8'(rxData);
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: tb/tb_sync_slave_rx.sv
module tb_sync_slave_rx;
  logic clk = 0, rstN = 0, serClk = 0, serData = 0;
  logic [1:0] regAddr = 0;
  logic regWrEn = 0, regRdEn = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] regRdData;
  logic irq;
  int checks = 0, failures = 0;
  logic idleLvl = 0;
  logic expNinth = 0;
  logic [7:0] rd;

  sync_slave_rx dut (.clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .irq(irq));

  always #10 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [7:0] expStatus(input logic done, input logic ovr, input logic nin);
    return {5'b0, done, ovr, nin};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); regAddr = a; regWrData = v; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; regRdEn = 1; #1 v = regRdData;
    @(negedge clk); regRdEn = 0;
  endtask

  task automatic peekReg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; #1 v = regRdData;
  endtask

  task automatic sendBit(input logic b);
    serData = b; repeat (4) @(negedge clk);
    serClk = ~idleLvl; repeat (6) @(negedge clk);
    serClk = idleLvl;  repeat (6) @(negedge clk);
  endtask

  task automatic sendWord(input logic [8:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) sendBit(w[i]);
    repeat (8) @(negedge clk);
  endtask

  task automatic setIdle(input logic lvl);
    idleLvl = lvl; serClk = lvl; repeat (8) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    peekReg(0, rd); check("R1 ctrl", rd, 0);
    peekReg(1, rd); check("R1 status", rd, 0);
    peekReg(2, rd); check("R1 data", rd, 0);
    check("R1 irq", irq, 0);

    // R2: master select set, then port disabled: edges ignored
    writeReg(0, 8'h0F); sendWord(9'h0A5, 8);
    peekReg(1, rd); check("R2 master set no rx", rd, expStatus(0, 0, expNinth));
    writeReg(0, 8'h0A); sendWord(9'h0A5, 8);
    peekReg(1, rd); check("R2 port off no rx", rd, expStatus(0, 0, expNinth));
    peekReg(2, rd); check("R2 data untouched", rd, 0);

    // R5/R4: rising edge 8-bit
    writeReg(0, 8'h0B); sendWord(9'h03C, 8);
    peekReg(1, rd); check("R5 status", rd, expStatus(1, 0, 0));
    check("R7 irq disabled", irq, 0);
    readReg(2, rd); check("R4 data lsb first", rd, 8'h3C);
    peekReg(1, rd); check("R8 read clears done", rd, expStatus(0, 0, 0));

    // R3: single-receive bit has no effect
    writeReg(0, 8'h1B); sendWord(9'h081, 8);
    readReg(2, rd); check("R3 single set still rx", rd, 8'h81);
    writeReg(0, 8'h13); sendWord(9'h0FF, 8);
    peekReg(1, rd); check("R3 single only no rx", rd, expStatus(0, 0, 0));

    // R7: interrupt
    writeReg(0, 8'h8B); sendWord(9'h066, 8);
    check("R7 irq high", irq, 1);
    readReg(2, rd); check("R7 data", rd, 8'h66);
    check("R7 irq low after read", irq, 0);
    writeReg(0, 8'h0B);

    // R6: 9-bit
    writeReg(0, 8'h2B); sendWord(9'h1C3, 9); expNinth = 1;
    peekReg(1, rd); check("R6 status ninth", rd, expStatus(1, 0, 1));
    readReg(2, rd); check("R6 data", rd, 8'hC3);
    peekReg(1, rd); check("R6 ninth held", rd, expStatus(0, 0, 1));

    // R4: falling edge
    writeReg(0, 8'h43); setIdle(1);
    writeReg(0, 8'h4B); sendWord(9'h05A, 8); expNinth = 0;
    readReg(2, rd); check("R4 falling edge data", rd, 8'h5A);
    peekReg(1, rd); check("R5 ninth zero in 8-bit", rd, expStatus(0, 0, 0));
    writeReg(0, 8'h03); setIdle(0);

    // R9: overrun
    writeReg(0, 8'h0B);
    sendWord(9'h011, 8); sendWord(9'h022, 8);
    peekReg(1, rd); check("R9 overrun set", rd, expStatus(1, 1, 0));
    readReg(2, rd); check("R9 first word kept", rd, 8'h11);
    writeReg(0, 8'h2B); sendWord(9'h133, 9);
    peekReg(1, rd); check("R9 discarded after read", rd, expStatus(0, 1, 0));
    peekReg(2, rd); check("R9 data unchanged", rd, 8'h11);

    // R11: writes to other addresses ignored
    writeReg(1, 8'hFF); writeReg(2, 8'hAA); writeReg(3, 8'h55);
    peekReg(1, rd); check("R11 status not writable", rd, expStatus(0, 1, 0));
    peekReg(2, rd); check("R11 data not writable", rd, 8'h11);
    peekReg(3, rd); check("R11 addr3 zero", rd, 0);
    peekReg(0, rd); check("R11 ctrl kept", rd, 8'h2B);

    // R10: clear by dropping continuous enable, abort partial word
    writeReg(0, 8'h03);
    peekReg(1, rd); check("R10 overrun cleared", rd, expStatus(0, 0, 0));
    writeReg(0, 8'h0B);
    sendBit(1); sendBit(1); sendBit(1);
    writeReg(0, 8'h03); writeReg(0, 8'h0B);
    sendWord(9'h077, 8);
    readReg(2, rd); check("R10 realigned word", rd, 8'h77);

    // random stream
    for (int n = 0; n < 30; n++) begin
      logic [8:0] w;
      logic nine, ie;
      w = 9'($urandom);
      nine = 1'($urandom);
      ie = 1'($urandom);
      writeReg(0, {ie, 1'b0, nine, 1'($urandom), 4'hB});
      sendWord(w, nine ? 9 : 8);
      expNinth = nine ? w[8] : 1'b0;
      peekReg(1, rd); check("R6 random status", rd, expStatus(1, 0, expNinth));
      check("R7 random irq", irq, ie);
      readReg(2, rd); check("R5 random data", rd, w[7:0]);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule